// File: doc/BRIEF.md
# Sorted Hardware Sleep Queue

This block holds threads that have asked to sleep, ordered by the absolute time at which each must wake. Software or a hardware agent issues one command at a time on a request/acknowledge port. It first loads a 64-bit sleep interval for a thread as two 32-bit halves, then issues a sleep command. The block adds the interval to its free-running nanosecond counter to form a deadline. It then links the thread into a doubly-linked list kept in synchronous-read RAM, indexed by thread ID.

The earliest entry of the list is always shown on the head outputs: thread ID, deadline and a valid flag. A separate wakeup monitor compares that deadline with the counter and, when it is due, sends a dequeue command. Dequeue can also remove a thread from any other position. A status word can be read for debugging. Every command finishes in a fixed number of cycles that is known before it is issued.

Top module: `sleep_queue`

## Requirements
- R1: After reset `cmd_ack` and `head_valid` are 0, and a status read reports an occupancy of 0.
- R2: Opcode 0 writes bits 31:0 and opcode 1 writes bits 63:32 of the addressed thread's sleep interval. Each is acknowledged without error 4 cycles after the command is sampled.
- R3: `now_ns` advances by `NS_STEP` (default 4) every clock. A sleep (opcode 2) gives the thread the deadline interval + `now_ns`, taking `now_ns` as seen in the cycle after the sampling edge.
- R4: After every command, `head_tid` and `head_deadline` show the queued thread with the smallest deadline, and `head_valid` is 1 exactly when the queue is not empty.
- R5: Threads with equal deadlines leave the head in the order in which they were put to sleep.
- R6: A sleep into an empty queue makes that thread both the head and the tail.
- R7: A thread whose deadline is not earlier than any queued entry is appended. It becomes the tail, which the status word shows in bits 23:16.
- R8: An accepted sleep is acknowledged 9 + 3·X cycles after the command is sampled, where X is the number of threads queued beforehand. This holds whatever the insert position.
- R9: Dequeue (opcode 3) of a queued thread at any position removes it in 8 cycles without error. The rest of the list keeps its order.
- R10: A dequeue of a thread that is not queued, or a sleep of a thread that is already queued, is acknowledged with `cmd_err` = 1 after 2 cycles and leaves the queue unchanged.
- R11: A status read (opcode 4) is acknowledged after 4 cycles. Bits 8:0 hold the occupancy, bits 23:16 the tail thread ID (0 when empty), and bit 31 holds the error flag of the previous command.
- R12: `cmd_ack` is a single-cycle pulse, and is raised only while a command is in progress.
- R13: Opcodes 5 to 7 are rejected with `cmd_err` = 1 after 2 cycles and leave the queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_req | input | 1 | Command request, held until acknowledged |
| cmd_op | input | 3 | Opcode: 0 low half, 1 high half, 2 sleep, 3 dequeue, 4 status |
| cmd_tid | input | 8 | Thread ID addressed by the command |
| cmd_wdata | input | 32 | Interval half for opcodes 0 and 1 |
| cmd_ack | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Rejection flag, valid with `cmd_ack` |
| cmd_rdata | output | 32 | Status word, valid with the acknowledge of opcode 4 |
| now_ns | output | 64 | Free-running nanosecond time base |
| head_valid | output | 1 | Queue is not empty |
| head_tid | output | 8 | Thread ID at the head |
| head_deadline | output | 64 | Deadline of the head entry, meaningful while `head_valid` is 1 |

## Verification
A command is sampled on a rising edge and its acknowledge becomes visible after the Nth following edge, with N equal to 4, 8, 2 or 9 + 3·X. The bench counts rising edges from the sampling edge and compares the count at the first acknowledge against the value its model predicts. It records `now_ns` one edge after sampling, because that is the value added to form a deadline. Head outputs and status fields are read in the low phase right after the acknowledge, when every register update of the command has settled.

// File: rtl/sq_pkg.sv
package sq_pkg;

    typedef enum logic [2:0] {
        OP_WLO   = 3'd0,
        OP_WHI   = 3'd1,
        OP_SLEEP = 3'd2,
        OP_DEQ   = 3'd3,
        OP_DEBUG = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WALK,
        ST_LINK1,
        ST_LINK2,
        ST_UNL1,
        ST_UNL2,
        ST_HOLD
    } st_e;

    localparam int LAT_WRITE  = 4;
    localparam int LAT_DEQ    = 8;
    localparam int LAT_DEBUG  = 4;
    localparam int LAT_REJECT = 2;

    function automatic int sleep_cycles(int occ);
        return 9 + 3 * occ;
    endfunction

endpackage

// File: rtl/sq_ram.sv
module sq_ram #(
    parameter int W  = 64,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/sq_ns_counter.sv
module sq_ns_counter #(
    parameter int W    = 64,
    parameter int STEP = 4
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + W'(STEP);
    end
endmodule

// File: rtl/sleep_queue.sv
module sleep_queue
    import sq_pkg::*;
#(
    parameter int TID_W   = 8,
    parameter int HALF_W  = 32,
    parameter int NS_STEP = 4,
    parameter int DBG_W   = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_req,
    input  logic [2:0]            cmd_op,
    input  logic [TID_W-1:0]      cmd_tid,
    input  logic [HALF_W-1:0]     cmd_wdata,
    output logic                  cmd_ack,
    output logic                  cmd_err,
    output logic [DBG_W-1:0]      cmd_rdata,
    output logic [2*HALF_W-1:0]   now_ns,
    output logic                  head_valid,
    output logic [TID_W-1:0]      head_tid,
    output logic [2*HALF_W-1:0]   head_deadline
);
    localparam int DEPTH    = 1 << TID_W;
    localparam int PTR_W    = TID_W + 1;
    localparam int TIME_W   = 2 * HALF_W;
    localparam int CNT_W    = TID_W + 1;
    localparam int TMR_W    = CNT_W + 4;
    localparam int TAIL_LSB = 16;

    typedef logic [PTR_W-1:0] ptr_t;
    localparam ptr_t NULLP = ptr_t'(1) << TID_W;

    function automatic logic is_null(ptr_t p);
        return p[PTR_W-1];
    endfunction

    st_e                 st;
    logic [TMR_W-1:0]    tmr;
    logic [TID_W-1:0]    tid_r;
    ptr_t                cur_r, lp, ln, head, tail;
    logic [TIME_W-1:0]   new_dl, hdl;
    logic [CNT_W-1:0]    cnt;
    logic [DEPTH-1:0]    queued;
    logic                ack_r, err_r, err_p, last_err;
    logic [DBG_W-1:0]    rdata_r, dbg_word;
    logic                busy;

    logic [HALF_W-1:0]   half_q [2];
    logic [TIME_W-1:0]   dl_q, sum;
    ptr_t                nxt_q, prv_q, raddr, tidp, nxt_wd, prv_wd;
    logic                dl_we, nxt_we, prv_we;
    logic [TID_W-1:0]    nxt_wa, prv_wa;

    assign tidp = {1'b0, tid_r};
    assign busy = (st != ST_IDLE);
    assign sum  = {half_q[1], half_q[0]} + now_ns;

    sq_ns_counter #(.W(TIME_W), .STEP(NS_STEP)) u_time (
        .clk(clk), .rst(rst), .count(now_ns)
    );

    // One RAM per interval half, written straight from the command port.
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic we_h;
        assign we_h = !busy && cmd_req &&
                      (op_e'(cmd_op) == ((h == 0) ? OP_WLO : OP_WHI));
        sq_ram #(.W(HALF_W), .AW(TID_W)) u_half (
            .clk(clk), .we(we_h), .waddr(cmd_tid), .wdata(cmd_wdata),
            .raddr(cmd_tid), .rdata(half_q[h])
        );
    end

    sq_ram #(.W(TIME_W), .AW(TID_W)) u_dl (
        .clk(clk), .we(dl_we), .waddr(tid_r), .wdata(sum),
        .raddr(raddr[TID_W-1:0]), .rdata(dl_q)
    );
    sq_ram #(.W(PTR_W), .AW(TID_W)) u_nxt (
        .clk(clk), .we(nxt_we), .waddr(nxt_wa), .wdata(nxt_wd),
        .raddr(raddr[TID_W-1:0]), .rdata(nxt_q)
    );
    sq_ram #(.W(PTR_W), .AW(TID_W)) u_prv (
        .clk(clk), .we(prv_we), .waddr(prv_wa), .wdata(prv_wd),
        .raddr(raddr[TID_W-1:0]), .rdata(prv_q)
    );

    always_comb begin
        dbg_word = '0;
        dbg_word[CNT_W-1:0]          = cnt;
        dbg_word[TAIL_LSB +: TID_W]  = tail[TID_W-1:0];
        dbg_word[DBG_W-1]            = last_err;
    end

    // RAM addressing and pointer writes per state.
    always_comb begin
        raddr  = {1'b0, cmd_tid};
        dl_we  = 1'b0;
        nxt_we = 1'b0;
        prv_we = 1'b0;
        nxt_wa = tid_r;
        prv_wa = tid_r;
        nxt_wd = NULLP;
        prv_wd = NULLP;
        case (st)
            ST_LOAD: begin
                raddr = head;
                dl_we = 1'b1;
            end
            ST_WALK: raddr = nxt_q;
            ST_UNL1: begin
                raddr  = nxt_q;
                nxt_we = !is_null(prv_q);
                nxt_wa = prv_q[TID_W-1:0];
                nxt_wd = nxt_q;
                prv_we = !is_null(nxt_q);
                prv_wa = nxt_q[TID_W-1:0];
                prv_wd = prv_q;
            end
            ST_LINK1: begin
                nxt_we = !is_null(lp);
                nxt_wa = lp[TID_W-1:0];
                nxt_wd = tidp;
                prv_we = !is_null(ln);
                prv_wa = ln[TID_W-1:0];
                prv_wd = tidp;
            end
            ST_LINK2: begin
                nxt_we = 1'b1;
                nxt_wd = ln;
                prv_we = 1'b1;
                prv_wd = lp;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            tmr      <= '0;
            tid_r    <= '0;
            cur_r    <= NULLP;
            lp       <= NULLP;
            ln       <= NULLP;
            head     <= NULLP;
            tail     <= NULLP;
            new_dl   <= '0;
            hdl      <= '0;
            cnt      <= '0;
            queued   <= '0;
            ack_r    <= 1'b0;
            err_r    <= 1'b0;
            err_p    <= 1'b0;
            last_err <= 1'b0;
            rdata_r  <= '0;
        end else begin
            ack_r <= 1'b0;
            err_r <= 1'b0;
            if (busy) tmr <= tmr - 1'b1;
            case (st)
                ST_IDLE: if (cmd_req) begin
                    tid_r <= cmd_tid;
                    err_p <= 1'b0;
                    case (op_e'(cmd_op))
                        OP_WLO, OP_WHI: begin
                            tmr <= TMR_W'(LAT_WRITE - 1);
                            st  <= ST_HOLD;
                        end
                        OP_DEBUG: begin
                            rdata_r <= dbg_word;
                            tmr     <= TMR_W'(LAT_DEBUG - 1);
                            st      <= ST_HOLD;
                        end
                        OP_SLEEP: if (queued[cmd_tid]) begin
                            err_p <= 1'b1;
                            tmr   <= TMR_W'(LAT_REJECT - 1);
                            st    <= ST_HOLD;
                        end else begin
                            tmr <= TMR_W'(sleep_cycles(int'(cnt)) - 1);
                            st  <= ST_LOAD;
                        end
                        OP_DEQ: if (!queued[cmd_tid]) begin
                            err_p <= 1'b1;
                            tmr   <= TMR_W'(LAT_REJECT - 1);
                            st    <= ST_HOLD;
                        end else begin
                            tmr <= TMR_W'(LAT_DEQ - 1);
                            st  <= ST_UNL1;
                        end
                        default: begin
                            err_p <= 1'b1;
                            tmr   <= TMR_W'(LAT_REJECT - 1);
                            st    <= ST_HOLD;
                        end
                    endcase
                end
                ST_LOAD: begin
                    new_dl <= sum;
                    if (is_null(head)) begin
                        lp <= NULLP;
                        ln <= NULLP;
                        st <= ST_LINK1;
                    end else begin
                        cur_r <= head;
                        st    <= ST_WALK;
                    end
                end
                ST_WALK: begin
                    if (dl_q > new_dl) begin
                        lp <= prv_q;
                        ln <= cur_r;
                        st <= ST_LINK1;
                    end else if (cur_r == tail) begin
                        lp <= cur_r;
                        ln <= NULLP;
                        st <= ST_LINK1;
                    end else begin
                        cur_r <= nxt_q;
                    end
                end
                ST_LINK1: begin
                    if (is_null(lp)) begin
                        head <= tidp;
                        hdl  <= new_dl;
                    end
                    if (is_null(ln)) tail <= tidp;
                    st <= ST_LINK2;
                end
                ST_LINK2: begin
                    queued[tid_r] <= 1'b1;
                    cnt           <= cnt + 1'b1;
                    st            <= ST_HOLD;
                end
                ST_UNL1: begin
                    if (is_null(prv_q)) head <= nxt_q;
                    if (is_null(nxt_q)) tail <= prv_q;
                    lp            <= prv_q;
                    queued[tid_r] <= 1'b0;
                    cnt           <= cnt - 1'b1;
                    st            <= ST_UNL2;
                end
                ST_UNL2: begin
                    if (is_null(lp)) hdl <= dl_q;
                    st <= ST_HOLD;
                end
                ST_HOLD: if (tmr == TMR_W'(1)) begin
                    ack_r    <= 1'b1;
                    err_r    <= err_p;
                    last_err <= err_p;
                    st       <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ack       = ack_r;
    assign cmd_err       = err_r;
    assign cmd_rdata     = rdata_r;
    assign head_valid    = !is_null(head);
    assign head_tid      = head[TID_W-1:0];
    assign head_deadline = hdl;

endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
    parameter int TID_W   = 8,
    parameter int TIME_W  = 64,
    parameter int NS_STEP = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              busy,
    input logic              ack,
    input logic              err,
    input logic              head_valid,
    input logic [TID_W-1:0]  head_tid,
    input logic [TIME_W-1:0] now_ns,
    input logic [TID_W:0]    occ
);
    localparam int DEPTH = 1 << TID_W;

    assert_ack_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    assert_ack_after_busy_R12: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(busy));

    assert_err_with_ack_R10: assert property (@(posedge clk) disable iff (rst)
        err |-> ack);

    assert_time_step_R3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> now_ns == $past(now_ns) + TIME_W'(NS_STEP));

    assert_head_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req) |=> ($stable(head_valid) && $stable(head_tid)));

    assert_head_matches_occ_R6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (head_valid == (occ != '0)));

    assert_occ_bound_R9: assert property (@(posedge clk) disable iff (rst)
        int'(occ) <= DEPTH);

endmodule

bind sleep_queue sq_checker #(
    .TID_W(TID_W), .TIME_W(2 * HALF_W), .NS_STEP(NS_STEP)
) i_sq_checker (
    .clk(clk), .rst(rst), .req(cmd_req), .busy(busy), .ack(cmd_ack),
    .err(cmd_err), .head_valid(head_valid), .head_tid(head_tid),
    .now_ns(now_ns), .occ(cnt)
);

// File: tb/test_sleep_queue.sv
`timescale 1ns/1ps
module test_sleep_queue;
    localparam int TID_W = 8;
    localparam int HALF_W = 32;
    localparam int STEP = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_req;
    logic [2:0]  cmd_op;
    logic [7:0]  cmd_tid;
    logic [31:0] cmd_wdata;
    logic        cmd_ack, cmd_err;
    logic [31:0] cmd_rdata;
    logic [63:0] now_ns, head_deadline;
    logic        head_valid;
    logic [7:0]  head_tid;

    always #2 clk = ~clk;

    sleep_queue #(.TID_W(TID_W), .HALF_W(HALF_W), .NS_STEP(STEP)) i_sleep_queue (
        .clk(clk), .rst(rst), .cmd_req(cmd_req), .cmd_op(cmd_op),
        .cmd_tid(cmd_tid), .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack),
        .cmd_err(cmd_err), .cmd_rdata(cmd_rdata), .now_ns(now_ns),
        .head_valid(head_valid), .head_tid(head_tid),
        .head_deadline(head_deadline)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;
    int          q_tid[$];
    logic [63:0] q_dl[$];
    logic [63:0] mdelta[256];
    bit          mq[256];
    bit          m_lasterr = 0;

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Called in the low phase; returns in the low phase after the acknowledge.
    task automatic do_cmd(input logic [2:0] op, input int t, input logic [31:0] wd,
                          output int cyc, output logic e, output logic [31:0] rd,
                          output logic [63:0] t1);
        cmd_req = 1'b1; cmd_op = op; cmd_tid = 8'(t); cmd_wdata = wd;
        cyc = 0; t1 = '0;
        while (1) begin
            @(posedge clk); cyc++;
            @(negedge clk);
            if (cyc == 1) t1 = now_ns;
            if (cmd_ack || cyc > 1000) break;
        end
        e = cmd_err; rd = cmd_rdata;
        cmd_req = 1'b0;
    endtask

    task automatic check_head(string tag);
        if (q_tid.size() == 0) check(tag, "head_valid", 64'(head_valid), 64'd0);
        else begin
            check(tag, "head_valid", 64'(head_valid), 64'd1);
            check(tag, "head_tid", 64'(head_tid), 64'(q_tid[0]));
            check(tag, "head_deadline", head_deadline, q_dl[0]);
        end
    endtask

    task automatic set_delta(int t, logic [63:0] d);
        int c; logic e; logic [31:0] rd; logic [63:0] t1;
        do_cmd(3'd0, t, d[31:0], c, e, rd, t1);
        check("R2", "low write cycles", 64'(c), 64'd4);
        check("R2", "low write err", 64'(e), 64'd0);
        do_cmd(3'd1, t, d[63:32], c, e, rd, t1);
        check("R2", "high write cycles", 64'(c), 64'd4);
        check("R2", "high write err", 64'(e), 64'd0);
        mdelta[t] = d;
        m_lasterr = 0;
    endtask

    task automatic sleep_t(int t, output logic [63:0] dl);
        int c; logic e; logic [31:0] rd; logic [63:0] t1; int pos; int exp_c;
        exp_c = mq[t] ? 2 : 9 + 3 * q_tid.size();
        do_cmd(3'd2, t, 32'd0, c, e, rd, t1);
        dl = '0;
        if (mq[t]) begin
            check("R10", "sleep reject cycles", 64'(c), 64'(exp_c));
            check("R10", "sleep reject err", 64'(e), 64'd1);
            m_lasterr = 1;
            check_head("R10");
        end else begin
            check("R8", "sleep cycles", 64'(c), 64'(exp_c));
            check("R8", "sleep err", 64'(e), 64'd0);
            dl = mdelta[t] + t1;
            pos = q_tid.size();
            for (int i = 0; i < q_tid.size(); i++)
                if (q_dl[i] > dl) begin pos = i; break; end
            q_tid.insert(pos, t);
            q_dl.insert(pos, dl);
            mq[t] = 1;
            m_lasterr = 0;
            check_head("R4");
        end
    endtask

    task automatic deq_t(int t);
        int c; logic e; logic [31:0] rd; logic [63:0] t1;
        do_cmd(3'd3, t, 32'd0, c, e, rd, t1);
        if (!mq[t]) begin
            check("R10", "dequeue reject cycles", 64'(c), 64'd2);
            check("R10", "dequeue reject err", 64'(e), 64'd1);
            m_lasterr = 1;
            check_head("R10");
        end else begin
            check("R9", "dequeue cycles", 64'(c), 64'd8);
            check("R9", "dequeue err", 64'(e), 64'd0);
            for (int i = 0; i < q_tid.size(); i++)
                if (q_tid[i] == t) begin q_tid.delete(i); q_dl.delete(i); break; end
            mq[t] = 0;
            m_lasterr = 0;
            check_head("R9");
        end
    endtask

    task automatic dbg(string tag);
        int c; logic e; logic [31:0] rd; logic [63:0] t1; int exp_tail;
        do_cmd(3'd4, 0, 32'd0, c, e, rd, t1);
        exp_tail = (q_tid.size() == 0) ? 0 : q_tid[q_tid.size() - 1];
        check("R11", "status cycles", 64'(c), 64'd4);
        check("R11", "status last error bit", 64'(rd[31]), 64'(m_lasterr));
        check(tag, "status occupancy", 64'(rd[8:0]), 64'(q_tid.size()));
        check(tag, "status tail", 64'(rd[23:16]), 64'(exp_tail));
        m_lasterr = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] dl3, dl9, dl_x, v0, t_a;
        int c; logic e; logic [31:0] rd; logic [63:0] t1;
        void'($urandom(32'd20240611));
        rst = 1'b1; cmd_req = 1'b0; cmd_op = '0; cmd_tid = '0; cmd_wdata = '0;
        for (int i = 0; i < 256; i++) begin mdelta[i] = '0; mq[i] = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "ack after reset", 64'(cmd_ack), 64'd0);
        check("R1", "head_valid after reset", 64'(head_valid), 64'd0);
        dbg("R1");
        // R3: time base step
        t_a = now_ns;
        @(negedge clk);
        check("R3", "time base step", now_ns, t_a + 64'(STEP));

        // Directed sequence
        set_delta(3, 64'd1000);
        sleep_t(3, dl3);
        check("R3", "deadline = interval + time", head_deadline, 64'd1000 + (dl3 - 64'd1000));
        check("R6", "head after empty insert", 64'(head_tid), 64'd3);
        dbg("R6");
        set_delta(5, 64'd5000);
        sleep_t(5, dl_x);
        dbg("R7");
        set_delta(7, 64'd10);
        sleep_t(7, dl_x);
        check("R4", "earlier deadline becomes head", 64'(head_tid), 64'd7);
        // Equal deadline with thread 3: now at sleep sample = v0 + 8 edges of writes + 1
        v0 = now_ns;
        set_delta(9, dl3 - (v0 + 64'(9 * STEP)));
        sleep_t(9, dl9);
        check("R5", "tie deadline formed", dl9, dl3);
        set_delta(255, 64'h1_0000_0000);
        sleep_t(255, dl_x);
        dbg("R7");
        sleep_t(3, dl_x);
        dbg("R10");
        deq_t(12);
        do_cmd(3'd6, 3, 32'd0, c, e, rd, t1);
        check("R13", "bad opcode cycles", 64'(c), 64'd2);
        check("R13", "bad opcode err", 64'(e), 64'd1);
        m_lasterr = 1;
        check_head("R13");
        dbg("R13");
        deq_t(5);
        dbg("R9");
        deq_t(7);
        deq_t(3);
        check("R5", "tie partner follows in order", 64'(head_tid), 64'd9);
        deq_t(255);
        deq_t(9);
        dbg("R9");

        // Constrained random phase
        for (int t = 0; t < 16; t++) set_delta(t, 64'($urandom_range(0, 4000)));
        for (int it = 0; it < 600; it++) begin
            int r, t;
            r = $urandom_range(0, 19);
            t = $urandom_range(0, 15);
            if (r < 3) set_delta(t, 64'($urandom_range(0, 4000)));
            else if (r < 11) sleep_t(t, dl_x);
            else if (r < 15) begin
                if (q_tid.size() > 0 && r < 13) deq_t(q_tid[0]);
                else deq_t(t);
            end else if (r < 18) dbg("R11");
            else begin
                do_cmd(3'(5 + (r & 1)), t, 32'd0, c, e, rd, t1);
                check("R13", "bad opcode err", 64'(e), 64'd1);
                m_lasterr = 1;
                check_head("R13");
            end
        end
        while (q_tid.size() > 0) deq_t(q_tid[0]);
        dbg("R9");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule